// File: doc/BRIEF.md
# Combined Multi-Register Pseudo-Random Bit Source

This block produces one pseudo-random bit per enabled clock. Inside it, three linear feedback shift registers of unequal length run side by side. Each has its own feedback tap set, chosen so that the register alone is maximal-length. All three advance on the same shift enable. The output bit is the XOR of the top bit of every register. Because the three lengths differ, the combined sequence repeats only after the least common multiple of the three individual periods, which is far longer than any one register's period.

After reset every register holds a fixed nonzero default seed. A one-cycle seed-load strobe copies three seed buses into the registers. Any register whose seed is all zero gets its default instead, so a register can never lock up at zero. The lengths, tap sets and default seeds are parameters. The default configuration uses 64-, 63- and 61-bit registers, each with at most four taps.

Top module: `lfsr_mix`

## Requirements
- R1: Synchronous active-high reset `rst` loads every register with its default seed and clears `bit_valid`. Reset takes priority over `seed_load` and `shift_en`.
- R2: On a shift, register i with width W moves up by one place. Its new bit 0 is the XOR of the state bits selected by its tap mask, where tap position t is state bit t-1. Its contribution to the output is state bit W-1.
- R3: `rand_bit` equals the XOR of bit W-1 of the three current register states, with no register in the path after the states.
- R4: When `shift_en` is 1 and neither `rst` nor `seed_load` is 1 at a clock edge, every register shifts exactly once and `bit_valid` is 1 in the following cycle, together with the new `rand_bit`.
- R5: When `shift_en`, `seed_load` and `rst` are all 0 at a clock edge, all states hold, `rand_bit` is unchanged and `bit_valid` is 0 in the following cycle.
- R6: When `seed_load` is 1 at a clock edge without reset, each register takes its seed bus (`seed_a` for the first, `seed_b` for the second, `seed_c` for the third), no shift takes place even if `shift_en` is 1, and `bit_valid` is 0 in the following cycle.
- R7: During a seed load, a seed bus that is all zero loads that register's default seed. The other registers still take their own seeds.
- R8: Outside reset, no register state is ever all zero.
- R9: With default parameters the registers are 64 bits with taps 64,63,61,60; 63 bits with taps 63,62; and 61 bits with taps 61,60,46,45.
- R10: With widths 7, 5 and 3 and taps {7,6}, {5,3} and {3,2}, continuous shifting gives an output sequence that repeats after exactly 127*31*7 = 27559 shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Advance all registers by one step |
| seed_load | input | 1 | Load the seed buses into the registers |
| seed_a | input | W0 | Seed for the first register |
| seed_b | input | W1 | Seed for the second register |
| seed_c | input | W2 | Seed for the third register |
| rand_bit | output | 1 | XOR of the three register top bits |
| bit_valid | output | 1 | A fresh bit was produced by the last edge |

## Verification
The assertions assume that `rst` is 1 from time zero until the first edge, so register states are defined before any property is enabled. They also assume that `seed_load` and `shift_en` are driven to known levels on every edge. The stimulus always starts each configuration under reset, and it changes controls and seeds only between edges. Its seed patterns include all-zero and single-zero buses, and it deliberately asserts the load strobe and the enable together, so the load-over-shift priority is exercised inside the legal input space.

// File: rtl/lfsr_mix_pkg.sv
package lfsr_mix_pkg;

    localparam int unsigned NREG  = 3;
    localparam int unsigned MAX_W = 64;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_RESET = 2'd3
    } lfsr_op_e;

    typedef struct packed {
        lfsr_op_e op;
        logic     fresh;
    } lfsr_ctrl_t;

    // Build a tap mask from up to four tap positions (1-based, 0 = unused).
    function automatic logic [MAX_W-1:0] taps2mask(int unsigned a, int unsigned b,
                                                   int unsigned c, int unsigned d);
        logic [MAX_W-1:0] m;
        m = '0;
        if (a != 0) m[a-1] = 1'b1;
        if (b != 0) m[b-1] = 1'b1;
        if (c != 0) m[c-1] = 1'b1;
        if (d != 0) m[d-1] = 1'b1;
        return m;
    endfunction

    localparam logic [MAX_W-1:0] TAPS_A = taps2mask(64, 63, 61, 60);
    localparam logic [MAX_W-1:0] TAPS_B = taps2mask(63, 62, 0, 0);
    localparam logic [MAX_W-1:0] TAPS_C = taps2mask(61, 60, 46, 45);

    localparam logic [MAX_W-1:0] SEED_A = 64'hACE1_0F0F_1234_5679;
    localparam logic [MAX_W-1:0] SEED_B = 64'h1BAD_F00D_CAFE_0001;
    localparam logic [MAX_W-1:0] SEED_C = 64'h0DEC_AF00_5EED_1357;

endpackage

// File: rtl/lfsr_mix_ctrl.sv
module lfsr_mix_ctrl
    import lfsr_mix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       seed_load,
    input  logic       shift_en,
    output lfsr_ctrl_t ctrl,
    output logic       valid_q
);

    always_comb begin
        ctrl.fresh = 1'b0;
        if (rst) begin
            ctrl.op = OP_RESET;
        end else if (seed_load) begin
            ctrl.op = OP_LOAD;
        end else if (shift_en) begin
            ctrl.op    = OP_SHIFT;
            ctrl.fresh = 1'b1;
        end else begin
            ctrl.op = OP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        valid_q <= ctrl.fresh;
    end

endmodule

// File: rtl/lfsr_mix_stage.sv
module lfsr_mix_stage
    import lfsr_mix_pkg::*;
#(
    parameter int unsigned      WIDTH    = 64,
    parameter logic [MAX_W-1:0] TAP_MASK = TAPS_A,
    parameter logic [MAX_W-1:0] DEF_SEED = SEED_A
) (
    input  logic             clk,
    input  lfsr_op_e         op,
    input  logic [WIDTH-1:0] seed,
    output logic             top_bit,
    output logic             live
);

    localparam logic [WIDTH-1:0] TAP_W  = TAP_MASK[WIDTH-1:0];
    localparam logic [WIDTH-1:0] DEF_W  = DEF_SEED[WIDTH-1:0];
    localparam logic [WIDTH-1:0] SAFE_D = (DEF_W == '0) ? WIDTH'(1) : DEF_W;

    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] seeded;
    logic             fb;

    always_comb begin
        fb      = ^(state & TAP_W);
        stepped = {state[WIDTH-2:0], fb};
        seeded  = (seed == '0) ? SAFE_D : seed;
    end

    always_ff @(posedge clk) begin
        case (op)
            OP_RESET: state <= SAFE_D;
            OP_LOAD:  state <= seeded;
            OP_SHIFT: state <= stepped;
            default:  state <= state;
        endcase
    end

    assign top_bit = state[WIDTH-1];
    assign live    = |state;

endmodule

// File: rtl/lfsr_mix.sv
module lfsr_mix
    import lfsr_mix_pkg::*;
#(
    parameter int unsigned      W0 = 64,
    parameter int unsigned      W1 = 63,
    parameter int unsigned      W2 = 61,
    parameter logic [MAX_W-1:0] T0 = TAPS_A,
    parameter logic [MAX_W-1:0] T1 = TAPS_B,
    parameter logic [MAX_W-1:0] T2 = TAPS_C,
    parameter logic [MAX_W-1:0] D0 = SEED_A,
    parameter logic [MAX_W-1:0] D1 = SEED_B,
    parameter logic [MAX_W-1:0] D2 = SEED_C
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          seed_load,
    input  logic [W0-1:0] seed_a,
    input  logic [W1-1:0] seed_b,
    input  logic [W2-1:0] seed_c,
    output logic          rand_bit,
    output logic          bit_valid
);

    localparam int unsigned      WID [NREG] = '{W0, W1, W2};
    localparam logic [MAX_W-1:0] TAP [NREG] = '{T0, T1, T2};
    localparam logic [MAX_W-1:0] DEF [NREG] = '{D0, D1, D2};

    lfsr_ctrl_t       ctrl;
    logic [MAX_W-1:0] seed_pad [NREG];
    logic [NREG-1:0]  top_bits;
    logic [NREG-1:0]  stage_live;

    assign seed_pad[0] = MAX_W'(seed_a);
    assign seed_pad[1] = MAX_W'(seed_b);
    assign seed_pad[2] = MAX_W'(seed_c);

    lfsr_mix_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .seed_load (seed_load),
        .shift_en  (shift_en),
        .ctrl      (ctrl),
        .valid_q   (bit_valid)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_stage
        lfsr_mix_stage #(
            .WIDTH    (WID[g]),
            .TAP_MASK (TAP[g]),
            .DEF_SEED (DEF[g])
        ) i_stage (
            .clk     (clk),
            .op      (ctrl.op),
            .seed    (seed_pad[g][WID[g]-1:0]),
            .top_bit (top_bits[g]),
            .live    (stage_live[g])
        );
    end

    lfsr_mix_xor #(.N(NREG)) i_xor (
        .bits_i (top_bits),
        .bit_o  (rand_bit)
    );

endmodule

module lfsr_mix_xor #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] bits_i,
    output logic         bit_o
);
    assign bit_o = ^bits_i;
endmodule

// File: rtl/lfsr_mix_chk.sv
module lfsr_mix_chk (
    input logic       clk,
    input logic       rst,
    input logic       shift_en,
    input logic       seed_load,
    input logic       rand_bit,
    input logic       bit_valid,
    input logic [2:0] stage_live
);

    // R1
    reset_clears_valid_chk: assert property (@(posedge clk)
        rst |=> !bit_valid);

    // R4
    shift_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !seed_load) |=> bit_valid);

    // R5
    idle_holds_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !seed_load) |=> ($stable(rand_bit) && !bit_valid));

    // R6
    load_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !bit_valid);

    // R8
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        stage_live == 3'b111);

endmodule

bind lfsr_mix lfsr_mix_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .seed_load  (seed_load),
    .rand_bit   (rand_bit),
    .bit_valid  (bit_valid),
    .stage_live (stage_live)
);

// File: tb/test_lfsr_mix.sv
`timescale 1ns/1ps
module test_lfsr_mix;

    localparam int PER = 27559;
    localparam int WIN = 200;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // default configuration
    logic        rst = 1'b1, en = 1'b0, ld = 1'b0;
    logic [63:0] sa = '0;
    logic [62:0] sb = '0;
    logic [60:0] sc = '0;
    logic        rb, rv;

    lfsr_mix i_lfsr_mix (
        .clk(clk), .rst(rst), .shift_en(en), .seed_load(ld),
        .seed_a(sa), .seed_b(sb), .seed_c(sc), .rand_bit(rb), .bit_valid(rv));

    // small configuration
    logic       srst = 1'b1, sen = 1'b0, sld = 1'b0;
    logic [6:0] ssa = '0;
    logic [4:0] ssb = '0;
    logic [2:0] ssc = '0;
    logic       srb, srv;

    lfsr_mix #(.W0(7), .W1(5), .W2(3),
               .T0(64'h60), .T1(64'h14), .T2(64'h6),
               .D0(64'h1), .D1(64'h1), .D2(64'h1)) i_lfsr_mix_small (
        .clk(clk), .rst(srst), .shift_en(sen), .seed_load(sld),
        .seed_a(ssa), .seed_b(ssb), .seed_c(ssc), .rand_bit(srb), .bit_valid(srv));

    // reference model
    logic [63:0] ms [3];
    int          mw [3];
    logic [63:0] mt [3];
    logic [63:0] md [3];

    function automatic logic [63:0] wmask(int w);
        return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] mstep(logic [63:0] s, logic [63:0] t, int w);
        logic f;
        f = ^(s & t);
        return ((s << 1) | 64'(f)) & wmask(w);
    endfunction

    function automatic logic mout();
        logic o;
        o = 1'b0;
        for (int i = 0; i < 3; i++) o ^= ms[i][mw[i]-1];
        return o;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) ms[i] = md[i];
    endtask

    task automatic model_shift();
        for (int i = 0; i < 3; i++) ms[i] = mstep(ms[i], mt[i], mw[i]);
    endtask

    task automatic model_load(logic [63:0] a, logic [63:0] b, logic [63:0] c);
        logic [63:0] s [3];
        s[0] = a; s[1] = b; s[2] = c;
        for (int i = 0; i < 3; i++) ms[i] = (s[i] == 0) ? md[i] : s[i];
    endtask

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_default(int n, string req);
        logic e;
        for (int k = 0; k < n; k++) begin
            tick();
            e = mout();
            check(rb == e && rv == 1'b0 || 1'b0, req, {rb, rv}, {e, 1'b0});
        end
    endtask

    task automatic shift_default(int n, string req);
        logic e;
        en = 1'b1;
        for (int k = 0; k < n; k++) begin
            tick();
            model_shift();
            e = mout();
            check(rb == e && rv == 1'b1, req, {rb, rv}, {e, 1'b1});
        end
    endtask

    task automatic set_default_model();
        mw[0] = 64; mw[1] = 63; mw[2] = 61;
        mt[0] = 64'hD800_0000_0000_0000;   // taps 64,63,61,60
        mt[1] = 64'h6000_0000_0000_0000;   // taps 63,62
        mt[2] = 64'h1800_3000_0000_0000;   // taps 61,60,46,45
        md[0] = 64'hACE1_0F0F_1234_5679;
        md[1] = 64'h1BAD_F00D_CAFE_0001 & wmask(63);
        md[2] = 64'h0DEC_AF00_5EED_1357 & wmask(61);
    endtask

    task automatic set_small_model();
        mw[0] = 7;  mw[1] = 5;  mw[2] = 3;
        mt[0] = 64'h60; mt[1] = 64'h14; mt[2] = 64'h6;
        md[0] = 64'h1;  md[1] = 64'h1;  md[2] = 64'h1;
    endtask

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic        e;
        logic        prev;
        logic [WIN-1:0] first;
        set_default_model();

        // R1: reset wins over a simultaneous load
        sa = 64'h1234; sb = 63'h55; sc = 61'h77;
        ld = 1'b1; en = 1'b1; rst = 1'b1;
        tick(); tick();
        model_reset();
        e = mout();
        check(rv == 1'b0, "R1 valid after reset", rv, 0);
        check(rb == e, "R1 default seed bit", rb, e);
        ld = 1'b0; en = 1'b0; rst = 1'b0;
        tick();
        check(rb == e && rv == 1'b0, "R1 R5 idle after reset", {rb, rv}, {e, 1'b0});

        // R2 R3 R4 R9: continuous shifting with default taps
        shift_default(400, "R2 R3 R4 R9 shift");

        // R5: interleaved idle cycles
        for (int k = 0; k < 300; k++) begin
            en = (k % 3 != 0);
            prev = rb;
            tick();
            if (en) model_shift();
            e = mout();
            if (en) check(rb == e && rv, "R4 gapped shift", {rb, rv}, {e, 1'b1});
            else    check(rb == prev && rb == e && !rv, "R5 hold", {rb, rv}, {prev, 1'b0});
        end
        en = 1'b0;
        run_default(5, "R5 idle run");

        // R6: load beats enable
        sa = 64'hF0E1_D2C3_B4A5_9687;
        sb = 63'h2468_ACE0_1357_9BDF;
        sc = 61'h0F1E_2D3C_4B5A_6978;
        ld = 1'b1; en = 1'b1;
        tick();
        model_load(sa, 64'(sb), 64'(sc));
        e = mout();
        check(rb == e && !rv, "R6 load", {rb, rv}, {e, 1'b0});
        ld = 1'b0;
        shift_default(150, "R6 after load");

        // R7: one zero seed
        sa = 64'h8000_0000_0000_0001; sb = '0; sc = 61'h1;
        ld = 1'b1; en = 1'b0;
        tick();
        model_load(sa, 64'(sb), 64'(sc));
        e = mout();
        check(rb == e && !rv, "R7 single zero seed", {rb, rv}, {e, 1'b0});
        ld = 1'b0;
        shift_default(150, "R7 after single zero seed");

        // R7 R8: all seeds zero
        sa = '0; sb = '0; sc = '0;
        ld = 1'b1;
        tick();
        model_load(0, 0, 0);
        e = mout();
        check(rb == e && !rv, "R7 R8 all zero seeds", {rb, rv}, {e, 1'b0});
        ld = 1'b0;
        shift_default(200, "R8 after all zero seeds");

        // R10: small configuration, period sweep
        set_small_model();
        srst = 1'b1;
        tick(); tick();
        model_reset();
        e = mout();
        check(srb == e && !srv, "R1 small reset", {srb, srv}, {e, 1'b0});
        srst = 1'b0; sen = 1'b1;
        first = '0;
        for (int k = 0; k < PER + WIN; k++) begin
            tick();
            model_shift();
            e = mout();
            if (srb != e || !srv)
                check(1'b0, "R2 R10 small model", {srb, srv}, {e, 1'b1});
            if (k < WIN) first[k] = srb;
            if (k >= PER && srb != first[k-PER])
                check(1'b0, "R10 period repeat", srb, first[k-PER]);
        end
        check(1'b1, "R10 sweep", 0, 0);
        // model's own registers back at seed after their periods
        for (int i = 0; i < 3; i++) begin
            logic [63:0] s;
            s = md[i];
            for (int k = 0; k < (1 << mw[i]) - 1; k++) s = mstep(s, mt[i], mw[i]);
            check(s == md[i], "R10 register period", s, md[i]);
        end
        sen = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule